// File: doc/BRIEF.md
# Codec Register Access Controller

This block sits between a processor's 32-bit word-addressed slave port and the link logic of an audio codec. Through it, software sets up a codec register number and a data word, then writes a command word to start an access. The block sends a single-cycle request to the link side. It waits for the link to report that the access is done. It then fires one of two single-cycle interrupts: one for a completed codec write and one for a codec read reply. When a read completes, the value returned by the codec is captured into a readable register.

The link side uses a minimal request/done exchange. `lnk_req` is a one-cycle valid strobe with no ready, so the link must accept it in that cycle; there is no back-pressure toward the processor. The link holds off nothing. Instead, while one access is outstanding, the controller itself refuses to issue another. `lnk_done` is a one-cycle completion strobe. On a read it carries the codec's value on `lnk_rdata`. Serial framing, slot timing and the codec are not part of this block.

Top module: `codec_regctl`

## Requirements
- R1: After reset, every register reads zero and `lnk_req`, `irq_wr_done` and `irq_rd_reply` are low.
- R2: The register index is the byte address shifted right by two, and the two low address bits are ignored. Index 0 is the command word, 1 the codec register number, 2 the outgoing data and 3 the incoming data. Indices 1, 2 and 3 read back the last full word written to them.
- R3: Writing the command word with bit 0 (start) set while idle puts `lnk_req` high for exactly the cycle after the write. In that cycle `lnk_wr` equals command bit 1 (1 = codec write). `lnk_addr` carries the low bits of the register number and `lnk_wdata` the low bits of the outgoing data. The command word then reads back with bit 0 clear and all other written bits kept.
- R4: Writing the command word with bit 0 clear stores the other bits and issues no request.
- R5: A `lnk_done` for an outstanding codec-write access raises `irq_wr_done` for exactly the cycle after `lnk_done`, and `irq_rd_reply` stays low.
- R6: A `lnk_done` for an outstanding codec-read access stores `lnk_rdata`, zero-extended, into the incoming-data register. In the same cycle that this value becomes readable, `irq_rd_reply` pulses for one cycle, and `irq_wr_done` stays low.
- R7: A start written while an access is outstanding issues no request and leaves the pending direction unchanged. The other bits of the command word are still stored.
- R8: Reads of indices 4 and above return zero, and writes to them change no register.
- R9: An access whose byte enables are not all set is ignored: a write changes nothing and a read returns zero.
- R10: A `lnk_done` while no access is outstanding raises no interrupt and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Slave access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_be | input | 4 | Byte enables, all four required |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the access |
| lnk_req | output | 1 | One-cycle access request to the link |
| lnk_wr | output | 1 | Direction of the pending access, 1 = codec write |
| lnk_addr | output | CADDR_W (7) | Codec register number |
| lnk_wdata | output | CDATA_W (16) | Data for a codec write |
| lnk_done | input | 1 | One-cycle completion from the link |
| lnk_rdata | input | CDATA_W (16) | Codec value on a read completion |
| irq_wr_done | output | 1 | One-cycle codec-write completion interrupt |
| irq_rd_reply | output | 1 | One-cycle codec-read reply interrupt |

## Verification
The bench builds the block with its defaults: a 6-bit byte address (16 word slots), a 7-bit codec register number and 16-bit codec data. With 16 slots, twelve unknown indices can be reached, so the harmless-offset rule is tested on both reads and writes. The 16-bit return path shows that the upper half of the incoming-data register is cleared on capture. Random streams of writes, reads, partial-enable accesses and completions, both expected and stray, also produce starts that collide with an outstanding access.

// File: rtl/codec_regctl_pkg.sv
package codec_regctl_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_REGS = 4;
  localparam int BE_W     = WORD_W / 8;

  typedef enum logic [1:0] {
    IDX_CMD   = 2'd0,
    IDX_CADDR = 2'd1,
    IDX_DOUT  = 2'd2,
    IDX_DIN   = 2'd3
  } reg_idx_e;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 1;
endpackage

// File: rtl/codec_regctl_regs.sv
module codec_regctl_regs
  import codec_regctl_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int CDATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              din_load,
  input  logic [CDATA_W-1:0] din_value,
  output logic              cmd_stb,
  output logic [WORD_W-1:0] caddr_q,
  output logic [WORD_W-1:0] dout_q,
  output logic [WORD_W-1:0] din_q
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              known, full_word, wr_hit, rd_hit;
  logic [WORD_W-1:0] regs_q [NUM_REGS];

  assign idx       = bus_addr[ADDR_W-1:2];
  assign known     = (idx < IDX_W'(NUM_REGS));
  assign full_word = (bus_be == {BE_W{1'b1}});
  assign wr_hit    = bus_sel && bus_wr && full_word && known;
  assign rd_hit    = bus_sel && !bus_wr && full_word && known;
  assign cmd_stb   = wr_hit && (idx[1:0] == IDX_CMD);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (g == int'(IDX_DIN) && din_load) begin
        regs_q[g] <= WORD_W'(din_value);
      end else if (wr_hit && idx[1:0] == 2'(g)) begin
        if (g == int'(IDX_CMD))
          regs_q[g] <= bus_wdata & ~(WORD_W'(1) << CMD_START_BIT);
        else
          regs_q[g] <= bus_wdata;
      end
    end
  end

  assign bus_rdata = rd_hit ? regs_q[idx[1:0]] : '0;
  assign caddr_q   = regs_q[IDX_CADDR];
  assign dout_q    = regs_q[IDX_DOUT];
  assign din_q     = regs_q[IDX_DIN];
endmodule

// File: rtl/codec_regctl_seq.sv
module codec_regctl_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_stb,
  input  logic start_dir,
  input  logic lnk_done,
  output logic lnk_req,
  output logic lnk_wr,
  output logic din_load,
  output logic irq_wr_done,
  output logic irq_rd_reply
);
  logic busy_q, dir_q, req_q, irq_w_q, irq_r_q;
  logic launch, finish;

  assign launch   = start_stb && !busy_q;
  assign finish   = busy_q && lnk_done;
  assign din_load = finish && !dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      dir_q   <= 1'b0;
      req_q   <= 1'b0;
      irq_w_q <= 1'b0;
      irq_r_q <= 1'b0;
    end else begin
      req_q   <= launch;
      irq_w_q <= finish && dir_q;
      irq_r_q <= finish && !dir_q;
      if (launch) begin
        busy_q <= 1'b1;
        dir_q  <= start_dir;
      end else if (finish) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign lnk_req      = req_q;
  assign lnk_wr       = dir_q;
  assign irq_wr_done  = irq_w_q;
  assign irq_rd_reply = irq_r_q;
endmodule

// File: rtl/codec_regctl.sv
module codec_regctl
  import codec_regctl_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int CADDR_W = 7,
  parameter int CDATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [3:0]         bus_be,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               lnk_req,
  output logic               lnk_wr,
  output logic [CADDR_W-1:0] lnk_addr,
  output logic [CDATA_W-1:0] lnk_wdata,
  input  logic               lnk_done,
  input  logic [CDATA_W-1:0] lnk_rdata,
  output logic               irq_wr_done,
  output logic               irq_rd_reply
);
  logic              cmd_stb, din_load;
  logic [WORD_W-1:0] caddr_q, dout_q, din_q;

  codec_regctl_regs #(.ADDR_W(ADDR_W), .CDATA_W(CDATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .din_load(din_load), .din_value(lnk_rdata),
    .cmd_stb(cmd_stb), .caddr_q(caddr_q), .dout_q(dout_q), .din_q(din_q)
  );

  codec_regctl_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_stb(cmd_stb && bus_wdata[CMD_START_BIT]),
    .start_dir(bus_wdata[CMD_DIR_BIT]),
    .lnk_done(lnk_done), .lnk_req(lnk_req), .lnk_wr(lnk_wr),
    .din_load(din_load), .irq_wr_done(irq_wr_done), .irq_rd_reply(irq_rd_reply)
  );

  assign lnk_addr  = caddr_q[CADDR_W-1:0];
  assign lnk_wdata = dout_q[CDATA_W-1:0];
endmodule

// File: rtl/codec_regctl_chk.sv
module codec_regctl_chk #(
  parameter int CDATA_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lnk_req,
  input logic               lnk_done,
  input logic [CDATA_W-1:0] lnk_rdata,
  input logic               irq_wr_done,
  input logic               irq_rd_reply,
  input logic [31:0]        din_q
);
  logic outst_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        outst_q <= 1'b0;
    else if (lnk_req)  outst_q <= 1'b1;
    else if (lnk_done) outst_q <= 1'b0;
  end

  // R3: request strobe lasts one cycle
  a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_req |=> !lnk_req);

  // R5 / R6: the two interrupts never fire together
  a_r5_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_wr_done && irq_rd_reply));

  // R7: no request while one is outstanding
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |=> !lnk_req);

  // R10: an interrupt needs a completion of an outstanding access
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_wr_done || irq_rd_reply) |-> $past(outst_q && lnk_done));

  // R6: returned value is in place when the reply pulse is seen
  a_r6_din_captured: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rd_reply |-> (din_q == 32'($past(lnk_rdata))));
endmodule

bind codec_regctl codec_regctl_chk #(.CDATA_W(CDATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lnk_req(lnk_req), .lnk_done(lnk_done),
  .lnk_rdata(lnk_rdata), .irq_wr_done(irq_wr_done),
  .irq_rd_reply(irq_rd_reply), .din_q(din_q)
);

// File: tb/codec_regctl_test.sv
module codec_regctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        lnk_req, lnk_wr, lnk_done = 1'b0;
  logic [6:0]  lnk_addr;
  logic [15:0] lnk_wdata, lnk_rdata = '0;
  logic        irq_wr_done, irq_rd_reply;

  int checks = 0, errors = 0;
  logic [31:0] m_reg [4];
  bit m_busy = 0, m_dir = 0;

  always #4 clk = ~clk;

  codec_regctl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .lnk_req(lnk_req), .lnk_wr(lnk_wr),
    .lnk_addr(lnk_addr), .lnk_wdata(lnk_wdata), .lnk_done(lnk_done),
    .lnk_rdata(lnk_rdata), .irq_wr_done(irq_wr_done), .irq_rd_reply(irq_rd_reply)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [5:0] a, logic [3:0] be);
    int idx = int'(a >> 2);
    return (be == 4'hF && idx < 4) ? m_reg[idx] : 32'h0;
  endfunction

  task automatic do_write(logic [5:0] a, logic [31:0] d, logic [3:0] be);
    bit exp_req = 0;
    int idx = int'(a >> 2);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (be == 4'hF && idx < 4) begin
      if (idx == 0) begin
        m_reg[0] = d & ~32'h1;
        if (d[0] && !m_busy) begin
          exp_req = 1; m_busy = 1; m_dir = d[1];
        end
      end else m_reg[idx] = d;
    end
    chk(lnk_req === exp_req, "R3 R4 R7 R9 request", 32'(lnk_req), 32'(exp_req));
    if (exp_req) begin
      chk(lnk_wr === m_dir, "R3 direction", 32'(lnk_wr), 32'(m_dir));
      chk(lnk_addr === m_reg[1][6:0], "R3 address", 32'(lnk_addr), 32'(m_reg[1][6:0]));
      chk(lnk_wdata === m_reg[2][15:0], "R3 data", 32'(lnk_wdata), 32'(m_reg[2][15:0]));
    end
  endtask

  task automatic do_read(logic [5:0] a, logic [3:0] be, string tag);
    logic [31:0] e;
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = be;
    #1;
    e = exp_read(a, be);
    chk(bus_rdata === e, tag, bus_rdata, e);
    bus_sel = 0;
  endtask

  task automatic do_done(logic [15:0] rd);
    bit ew = 0, er = 0;
    @(negedge clk);
    lnk_done = 1; lnk_rdata = rd;
    @(negedge clk);
    lnk_done = 0;
    if (m_busy) begin
      ew = m_dir; er = !m_dir;
      if (!m_dir) m_reg[3] = {16'h0, rd};
      m_busy = 0;
    end
    chk(irq_wr_done === ew, "R5 R10 write irq", 32'(irq_wr_done), 32'(ew));
    chk(irq_rd_reply === er, "R6 R10 reply irq", 32'(irq_rd_reply), 32'(er));
    @(negedge clk);
    chk(!irq_wr_done && !irq_rd_reply, "R5 R6 single pulse",
        {irq_wr_done, irq_rd_reply}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    chk(!lnk_req && !irq_wr_done && !irq_rd_reply, "R1 outputs",
        {lnk_req, irq_wr_done, irq_rd_reply}, 32'h0);
    for (int i = 0; i < 4; i++) do_read(6'(i * 4), 4'hF, "R1 reset value");

    // directed: codec write
    do_write(6'h04, 32'h0000_0055, 4'hF);
    do_write(6'h0B, 32'hCAFE_1234, 4'hF);          // R2 low bits ignored
    do_read(6'h08, 4'hF, "R2 outgoing data");
    do_write(6'h00, 32'hA5A5_0003, 4'hF);          // R3 start write
    do_read(6'h00, 4'hF, "R3 start bit clears");
    do_write(6'h00, 32'h0000_0001, 4'hF);          // R7 ignored while busy
    do_done(16'h1111);                             // R5
    // directed: codec read
    do_write(6'h00, 32'h0000_0001, 4'hF);
    do_done(16'hBEEF);                             // R6
    do_read(6'h0C, 4'hF, "R6 captured value");
    do_done(16'h7777);                             // R10 stray
    do_read(6'h0C, 4'hF, "R10 unchanged");
    do_write(6'h00, 32'h0000_0F02, 4'hF);          // R4 no start
    do_read(6'h00, 4'hF, "R4 bits kept");
    do_write(6'h20, 32'hFFFF_FFFF, 4'hF);          // R8 unknown
    do_read(6'h20, 4'hF, "R8 unknown reads zero");
    do_write(6'h04, 32'h0000_0011, 4'h3);          // R9 partial
    do_read(6'h04, 4'hF, "R9 partial write ignored");
    do_read(6'h04, 4'h1, "R9 partial read zero");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      logic [5:0] a = (op < 3) ? 6'($urandom_range(0, 3) * 4) : 6'($urandom_range(0, 63));
      logic [3:0] be = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
      if (op < 5)      do_write(a, $urandom, be);
      else if (op < 8) do_read(a, be, "R2 R8 R9 random read");
      else             do_done(16'($urandom));
    end
    do_read(6'h00, 4'hF, "R2 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule